// File: doc/BRIEF.md
# Synchronized Strobe Pulse Generator

This block turns an asynchronous start/stop strobe into pulses for downstream digitizers. The strobe comes from one of two places: a front control input, or a one-cycle pulse that a bus key write raises. A configuration bit selects which one is used.

In direct mode the selected strobe reaches the outputs through gates only, with no clocked element in the path. In programmed mode the strobe passes through a flop synchronizer and a rising-edge detector. Each leading edge then starts a delay of N+1 distribution clocks, followed by a pulse of L+1 clocks. Any edge that arrives while a delay or pulse is still running is dropped.

A veto bit blocks the external strobe input and the auxiliary stop input. A swap bit sets how the strobe and the auxiliary input are placed on the backplane START and STOP lines. The front strobe output always carries the strobe.

Top module: `strobe_pulse_gen`

## Requirements
- R1: With `cfg_src_key_i`=1 the strobe is taken from `key_strobe_i`. With `cfg_src_key_i`=0 it is taken from `ext_strobe_i`.
- R2: With `cfg_prog_i`=0 (direct mode), `front_strobe_o` equals the selected strobe in the same cycle, with no clock edge in between.
- R3: With `cfg_prog_i`=1, when the source rises between clock edges, `front_strobe_o` is high from the (N+4)th rising edge after that point. N is `cfg_delay_i`, and the count is 2 synchronizer stages, 1 edge stage and N+1 delay clocks.
- R4: In programmed mode the pulse lasts exactly L+1 clocks, where L is `cfg_len_i`. L=0 gives 1 clock and L=255 gives 256 clocks.
- R5: In programmed mode, a rising edge that is detected while a delay or pulse is in progress produces no extra pulse. A source held high produces only one pulse.
- R6: With `cfg_veto_i`=1, `ext_strobe_i` and `aux_stop_i` have no effect on any output in either mode. `key_strobe_i` still works.
- R7: With `cfg_swap_i`=0, `bp_start_o` carries the strobe and `bp_stop_o` carries the gated `aux_stop_i`. With `cfg_swap_i`=1 the two are exchanged. In every case `front_strobe_o` carries the strobe.
- R8: Synchronous reset `rst`=1 ends any delay or pulse. Programmed-mode outputs are low on the first edge with reset applied.
- R9: Setting `cfg_prog_i` to 0 abandons a pending delay or pulse. Returning to programmed mode does not resume it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Distribution clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_strobe_i | input | 1 | Asynchronous external strobe input |
| key_strobe_i | input | 1 | Strobe pulse raised by a bus key write |
| aux_stop_i | input | 1 | Auxiliary input for the backplane STOP/START line |
| cfg_src_key_i | input | 1 | Strobe source: 0 external, 1 key write |
| cfg_prog_i | input | 1 | Mode: 0 direct, 1 programmed |
| cfg_veto_i | input | 1 | 1 blocks the external strobe and auxiliary inputs |
| cfg_swap_i | input | 1 | 1 exchanges the backplane START/STOP roles |
| cfg_len_i | input | 8 | Pulse length L (width L+1 clocks) |
| cfg_delay_i | input | 24 | Delay N (N+1 clocks before the pulse) |
| front_strobe_o | output | 1 | Front strobe output |
| bp_start_o | output | 1 | Backplane START |
| bp_stop_o | output | 1 | Backplane STOP |

## Verification
A timer that jumps to the wrong state, or loads the wrong count, shows at `front_strobe_o`. The pulse starts on the wrong edge, has the wrong width, or a second pulse appears when a retrigger should have been ignored. Each of these is visible within N+L+5 clocks of the source edge. A routing or veto fault is combinational, so it shows on the backplane lines in the same cycle the inputs change. The bench checks every cycle of each programmed-mode event against the expected window, so an error of one clock in either the start or the end of the pulse is caught.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FIRE = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic src_key;
        logic prog;
        logic veto;
        logic swap;
    } strobe_ctl_t;

    typedef struct packed {
        logic start;
        logic stop;
    } bp_lines_t;

    function automatic bp_lines_t route_bp(input logic swap, input logic strobe, input logic aux);
        bp_lines_t r;
        r.start = swap ? aux : strobe;
        r.stop  = swap ? strobe : aux;
        return r;
    endfunction

endpackage

// File: rtl/strobe_sync_edge.sv
module strobe_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] chain;
    logic            prev_q;

    assign chain[0] = async_i;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i+1] <= 1'b0;
                else     chain[i+1] <= chain[i];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain[STAGES];
    end

    assign rise_o = chain[STAGES] & ~prev_q;
endmodule

// File: rtl/strobe_timer.sv
module strobe_timer
    import strobe_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int DLY_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             trig_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             pulse_o
);
    localparam int CNT_W = (DLY_W > LEN_W) ? DLY_W : LEN_W;

    tmr_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (trig_i) begin
                        state_q <= ST_WAIT;
                        cnt_q   <= CNT_W'(delay_i);
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_FIRE;
                        cnt_q   <= CNT_W'(len_i);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_FIRE: begin
                    if (cnt_q == '0) state_q <= ST_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign pulse_o = (state_q == ST_FIRE);
endmodule

// File: rtl/strobe_router.sv
module strobe_router
    import strobe_pkg::*;
(
    input  strobe_ctl_t ctl_i,
    input  logic        ext_i,
    input  logic        key_i,
    input  logic        aux_i,
    input  logic        pulse_i,
    output logic        raw_o,
    output logic        front_o,
    output bp_lines_t   bp_o
);
    logic aux_gated;
    logic strobe;

    assign raw_o     = ctl_i.src_key ? key_i : (ext_i & ~ctl_i.veto);
    assign aux_gated = aux_i & ~ctl_i.veto;
    assign strobe    = ctl_i.prog ? pulse_i : raw_o;
    assign front_o   = strobe;
    assign bp_o      = route_bp(ctl_i.swap, strobe, aux_gated);
endmodule

// File: rtl/strobe_pulse_gen.sv
module strobe_pulse_gen
    import strobe_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int DLY_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_strobe_i,
    input  logic             key_strobe_i,
    input  logic             aux_stop_i,
    input  logic             cfg_src_key_i,
    input  logic             cfg_prog_i,
    input  logic             cfg_veto_i,
    input  logic             cfg_swap_i,
    input  logic [LEN_W-1:0] cfg_len_i,
    input  logic [DLY_W-1:0] cfg_delay_i,
    output logic             front_strobe_o,
    output logic             bp_start_o,
    output logic             bp_stop_o
);
    strobe_ctl_t ctl;
    bp_lines_t   bp;
    logic        raw_strobe;
    logic        rise;
    logic        pulse;

    assign ctl.src_key = cfg_src_key_i;
    assign ctl.prog    = cfg_prog_i;
    assign ctl.veto    = cfg_veto_i;
    assign ctl.swap    = cfg_swap_i;

    strobe_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_strobe),
        .rise_o  (rise)
    );

    strobe_timer #(.LEN_W(LEN_W), .DLY_W(DLY_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en_i    (cfg_prog_i),
        .trig_i  (rise),
        .len_i   (cfg_len_i),
        .delay_i (cfg_delay_i),
        .pulse_o (pulse)
    );

    strobe_router u_route (
        .ctl_i   (ctl),
        .ext_i   (ext_strobe_i),
        .key_i   (key_strobe_i),
        .aux_i   (aux_stop_i),
        .pulse_i (pulse),
        .raw_o   (raw_strobe),
        .front_o (front_strobe_o),
        .bp_o    (bp)
    );

    assign bp_start_o = bp.start;
    assign bp_stop_o  = bp.stop;
endmodule

// File: rtl/strobe_pulse_gen_chk.sv
module strobe_pulse_gen_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ext_strobe_i,
    input logic             key_strobe_i,
    input logic             cfg_src_key_i,
    input logic             cfg_prog_i,
    input logic             cfg_veto_i,
    input logic             cfg_swap_i,
    input logic [LEN_W-1:0] cfg_len_i,
    input logic             front_strobe_o,
    input logic             bp_start_o,
    input logic             bp_stop_o
);
    logic [LEN_W+1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)                               hi_cnt <= '0;
        else if (cfg_prog_i && front_strobe_o) hi_cnt <= hi_cnt + 1'b1;
        else                                   hi_cnt <= '0;
    end

    AST_KEY_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (!cfg_prog_i && cfg_src_key_i) |-> (front_strobe_o == key_strobe_i)); // R1
    AST_EXT_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (!cfg_prog_i && !cfg_src_key_i && !cfg_veto_i) |-> (front_strobe_o == ext_strobe_i)); // R2
    AST_PULSE_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        hi_cnt <= ({2'b00, cfg_len_i} + 1'b1)); // R4
    AST_VETO_MASK: assert property (@(posedge clk) disable iff (rst)
        (cfg_veto_i && !cfg_src_key_i && !cfg_prog_i) |-> !front_strobe_o); // R6
    AST_VETO_AUX: assert property (@(posedge clk) disable iff (rst)
        (cfg_veto_i && !cfg_swap_i) |-> !bp_stop_o); // R6
    AST_ROUTE_SWAP: assert property (@(posedge clk) disable iff (rst)
        cfg_swap_i |-> (bp_stop_o == front_strobe_o)); // R7
    AST_ROUTE_STRAIGHT: assert property (@(posedge clk) disable iff (rst)
        !cfg_swap_i |-> (bp_start_o == front_strobe_o)); // R7
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && cfg_prog_i) |-> !front_strobe_o); // R8
endmodule

bind strobe_pulse_gen strobe_pulse_gen_chk #(.LEN_W(LEN_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ext_strobe_i   (ext_strobe_i),
    .key_strobe_i   (key_strobe_i),
    .cfg_src_key_i  (cfg_src_key_i),
    .cfg_prog_i     (cfg_prog_i),
    .cfg_veto_i     (cfg_veto_i),
    .cfg_swap_i     (cfg_swap_i),
    .cfg_len_i      (cfg_len_i),
    .front_strobe_o (front_strobe_o),
    .bp_start_o     (bp_start_o),
    .bp_stop_o      (bp_stop_o)
);

// File: tb/sim_strobe_pulse_gen.sv
module sim_strobe_pulse_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_strobe_i = 1'b0, key_strobe_i = 1'b0, aux_stop_i = 1'b0;
    logic        cfg_src_key_i = 1'b0, cfg_prog_i = 1'b0, cfg_veto_i = 1'b0, cfg_swap_i = 1'b0;
    logic [7:0]  cfg_len_i = '0;
    logic [23:0] cfg_delay_i = '0;
    logic        front_strobe_o, bp_start_o, bp_stop_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    strobe_pulse_gen u0 (
        .clk(clk), .rst(rst), .ext_strobe_i(ext_strobe_i), .key_strobe_i(key_strobe_i),
        .aux_stop_i(aux_stop_i), .cfg_src_key_i(cfg_src_key_i), .cfg_prog_i(cfg_prog_i),
        .cfg_veto_i(cfg_veto_i), .cfg_swap_i(cfg_swap_i), .cfg_len_i(cfg_len_i),
        .cfg_delay_i(cfg_delay_i), .front_strobe_o(front_strobe_o),
        .bp_start_o(bp_start_o), .bp_stop_o(bp_stop_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Window of the programmed pulse, counted in rising edges after the source rose
    function automatic logic exp_window(input int k, input int n, input int l);
        return (k >= n + 4) && (k <= n + 4 + l);
    endfunction

    function automatic logic exp_raw(input logic src, input logic ext, input logic key, input logic veto);
        return src ? key : (ext & ~veto);
    endfunction

    task automatic check_lines(input string tag, input logic strobe, input logic aux, input logic swap);
        chk({tag, " front"}, front_strobe_o, strobe);
        chk({tag, " start"}, bp_start_o, swap ? aux : strobe);
        chk({tag, " stop"},  bp_stop_o,  swap ? strobe : aux);
    endtask

    task automatic settle_low(input int cycles);
        @(negedge clk);
        ext_strobe_i = 1'b0;
        key_strobe_i = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    // One programmed-mode event; retrig_at < 0 means no second edge
    task automatic run_prog(input string tag, input bit use_key, input bit swap, input bit veto,
                            input int n, input int l, input int retrig_at);
        logic fire;
        logic e;
        @(negedge clk);
        cfg_prog_i = 1'b1;
        cfg_src_key_i = use_key;
        cfg_swap_i = swap;
        cfg_veto_i = veto;
        cfg_len_i = 8'(l);
        cfg_delay_i = 24'(n);
        aux_stop_i = 1'b0;
        repeat (4) @(negedge clk);
        fire = use_key || !veto;
        if (use_key) key_strobe_i = 1'b1;
        else         ext_strobe_i = 1'b1;
        for (int k = 1; k <= n + l + 12; k++) begin
            @(posedge clk);
            #1;
            e = fire && exp_window(k, n, l);
            check_lines(tag, e, 1'b0, swap);
            @(negedge clk);
            if (k == 1) key_strobe_i = 1'b0;
            if (k == 3) ext_strobe_i = 1'b0;
            if (k == retrig_at) begin
                if (use_key) key_strobe_i = 1'b1;
                else         ext_strobe_i = 1'b1;
            end
            if (k == retrig_at + 1) key_strobe_i = 1'b0;
        end
        settle_low(4);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic r, a;
        void'($urandom(32'd20240611));

        // R8: reset state
        repeat (3) @(posedge clk);
        #1;
        check_lines("R8 reset", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 R2 R6 R7: direct mode, random mixes
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            cfg_prog_i    = 1'b0;
            ext_strobe_i  = 1'($urandom);
            key_strobe_i  = 1'($urandom);
            aux_stop_i    = 1'($urandom);
            cfg_veto_i    = 1'($urandom);
            cfg_swap_i    = 1'($urandom);
            cfg_src_key_i = 1'($urandom);
            #1;
            r = exp_raw(cfg_src_key_i, ext_strobe_i, key_strobe_i, cfg_veto_i);
            a = aux_stop_i & ~cfg_veto_i;
            check_lines("R1 R2 R6 R7 direct", r, a, cfg_swap_i);
        end
        @(negedge clk);
        aux_stop_i = 1'b0;
        settle_low(4);

        // R3 R4: directed corners
        run_prog("R3 R4 n0 l0", 1'b0, 1'b0, 1'b0, 0, 0, -1);
        run_prog("R3 R4 n0 l1", 1'b1, 1'b1, 1'b0, 0, 1, -1);
        run_prog("R4 l255", 1'b0, 1'b0, 1'b0, 3, 255, -1);
        run_prog("R3 n1000", 1'b1, 1'b0, 1'b0, 1000, 2, -1);

        // R5: retrigger during pulse and during delay
        run_prog("R5 retrig pulse ext", 1'b0, 1'b0, 1'b0, 4, 6, 8);
        run_prog("R5 retrig wait key", 1'b1, 1'b1, 1'b0, 20, 3, 5);

        // R6: veto in programmed mode
        run_prog("R6 veto ext", 1'b0, 1'b0, 1'b1, 2, 3, -1);
        run_prog("R6 veto key passes", 1'b1, 1'b0, 1'b1, 2, 3, -1);

        // R3 R4 R7 R1: random programmed events
        for (int i = 0; i < 20; i++) begin
            run_prog("R3 R4 R7 R1 rand", 1'($urandom), 1'($urandom), 1'b0,
                     int'($urandom % 16), int'($urandom % 16), -1);
        end

        // R7 R6: auxiliary input in programmed mode
        @(negedge clk);
        cfg_prog_i = 1'b1; cfg_veto_i = 1'b0; cfg_swap_i = 1'b1; aux_stop_i = 1'b1;
        #1;
        check_lines("R7 aux swapped", 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        cfg_swap_i = 1'b0;
        #1;
        check_lines("R7 aux straight", 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        cfg_veto_i = 1'b1;
        #1;
        check_lines("R6 aux vetoed", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        aux_stop_i = 1'b0; cfg_veto_i = 1'b0;
        settle_low(4);

        // R9: leaving programmed mode abandons a pending delay
        @(negedge clk);
        cfg_src_key_i = 1'b0; cfg_prog_i = 1'b1; cfg_delay_i = 24'd30; cfg_len_i = 8'd3;
        repeat (4) @(negedge clk);
        ext_strobe_i = 1'b1;
        for (int k = 1; k <= 50; k++) begin
            @(posedge clk);
            #1;
            if (k > 12) chk("R9 abandoned", front_strobe_o, 1'b0);
            @(negedge clk);
            if (k == 3)  ext_strobe_i = 1'b0;
            if (k == 8)  cfg_prog_i = 1'b0;
            if (k == 10) cfg_prog_i = 1'b1;
        end
        settle_low(4);

        // R8: reset in the middle of a pulse
        @(negedge clk);
        cfg_delay_i = 24'd0; cfg_len_i = 8'd40;
        repeat (4) @(negedge clk);
        ext_strobe_i = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        chk("R8 pulse before reset", front_strobe_o, 1'b1);
        @(negedge clk);
        ext_strobe_i = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R8 reset ends pulse", front_strobe_o, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) begin
            @(posedge clk);
            #1;
            chk("R8 stays low", front_strobe_o, 1'b0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule